// File: doc/BRIEF.md
# Slow-Bus Access Cycle Stretcher

This block sits between a 2 MHz processor and its memory-mapped peripherals. It checks every bus address the processor presents and decides whether the access goes to ordinary memory, to a fast I/O register, or to a device on the 1 MHz peripheral bus. Slow-bus accesses are stretched so that they line up with the slow clock. The stretch lasts two or three fast cycles, and the parity of a running phase count picks between them. The block holds the processor with an active-high wait output until the final cycle of the access.

The processor flags each new access with `acc_valid`. During a stretch it holds the address stable and keeps `acc_valid` high. The block also makes coarse device selects for the I/O page: a display controller with a register-select port and a data port, a serial controller, and two interface adapters. It merges the interrupt outputs of the two adapters into a single processor interrupt request.

Top module: `slow_bus_stretcher`

## Requirements
- R1: An address below 0xFC00, or at 0xFF00 and above, is a memory access. It completes in the cycle it is presented: `cpu_wait` stays 0, `acc_done` is 1 in that cycle, and `io_sel` and `slow_sel` stay 0.
- R2: Addresses 0xFC00 through 0xFDFF are I/O slow-bus accesses, with `io_sel` and `slow_sel` both 1.
- R3: In page 0xFE, three ranges are slow-bus: 0xFE00–0xFE17, 0xFE40–0xFE7F and 0xFEC0–0xFEDF. Every other 0xFExx address is I/O with `slow_sel` 0 and completes in one cycle.
- R4: A slow-bus access lasts 2 cycles when `phase_odd` is 0 at its start and 3 cycles when it is 1. `cpu_wait` is 1 in every cycle of the access except the last. `acc_done` is 1 only in the last cycle.
- R5: `phase_odd` holds the parity of the total number of cycles used by completed accesses. It changes only after an access completes: a one-cycle access flips it, and a slow access of N cycles adds N. Cycles with no access leave it unchanged.
- R6: While `rst` is 1, and directly after it, `cpu_wait`, `acc_done` and `phase_odd` are 0.
- R7: For addresses 0xFE00–0xFE07, an even address raises `crtc_reg_sel` and an odd address raises `crtc_dat_sel`.
- R8: Addresses 0xFE08–0xFE0F raise `serial_sel`.
- R9: Addresses 0xFE40–0xFE5F raise `adapt_sel[0]`, and addresses 0xFE60–0xFE7F raise `adapt_sel[1]`.
- R10: `cpu_irq` is 1 in the same cycle whenever either bit of `adapt_irq` is 1, and 0 when both bits are 0.
- R11: All selects, `io_sel`, `slow_sel`, `acc_done` and `cpu_wait` are 0 in any cycle with no access in progress. An access is in progress when `acc_valid` is 1 or a stretch is under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 2 MHz bus clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Processor presents an access this cycle (held during a stretch) |
| addr | input | 16 | Bus address, held stable during a stretch |
| adapt_irq | input | 2 | Interrupt outputs of the two interface adapters |
| cpu_wait | output | 1 | Holds the processor while a stretch continues |
| acc_done | output | 1 | Access completes in this cycle |
| phase_odd | output | 1 | Parity of the slow-clock phase count |
| io_sel | output | 1 | Access lies in the I/O area 0xFC00–0xFEFF |
| slow_sel | output | 1 | Access goes to the 1 MHz peripheral bus |
| crtc_reg_sel | output | 1 | Display controller register-select/status port |
| crtc_dat_sel | output | 1 | Display controller data port |
| serial_sel | output | 1 | Serial controller select |
| adapt_sel | output | 2 | Interface adapter selects |
| cpu_irq | output | 1 | Merged interrupt request to the processor |

## Verification
The phase bit only ever reaches the ports through the length of the next slow access and through `phase_odd`. A wrong parity stays hidden until an access is made, so the bench checks `phase_odd` at the start of every access. Every address is swept, which mixes fast and slow accesses in many orders; any flip of the phase bit shows up within one access. A wrong countdown shows up at once as a wait pulse that is one cycle too long or too short in that same access. A decode fault at a single address boundary is caught because every one of the 65536 addresses is visited.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    localparam int ADDR_W      = 16;
    localparam int N_ADAPT     = 2;
    localparam int SLOW_BASE   = 2;
    localparam int MAX_STRETCH = SLOW_BASE + 1;
    localparam int DUR_W       = $clog2(MAX_STRETCH + 1);
    localparam int CNT_W       = $clog2(MAX_STRETCH);

    localparam logic [ADDR_W-1:0] IO_LO = 16'hFC00;
    localparam logic [ADDR_W-1:0] IO_HI = 16'hFEFF;

    localparam int N_SLOW = 4;
    localparam logic [N_SLOW-1:0][ADDR_W-1:0] SLOW_LO =
        {16'hFEC0, 16'hFE40, 16'hFE00, 16'hFC00};
    localparam logic [N_SLOW-1:0][ADDR_W-1:0] SLOW_HI =
        {16'hFEDF, 16'hFE7F, 16'hFE17, 16'hFDFF};

    localparam logic [ADDR_W-1:0] CRTC_LO    = 16'hFE00;
    localparam logic [ADDR_W-1:0] CRTC_HI    = 16'hFE07;
    localparam logic [ADDR_W-1:0] SERIAL_LO  = 16'hFE08;
    localparam logic [ADDR_W-1:0] SERIAL_HI  = 16'hFE0F;
    localparam logic [ADDR_W-1:0] ADAPT_BASE = 16'hFE40;
    localparam int                ADAPT_SPAN = 32;

    typedef struct packed {
        logic               io;
        logic               slow;
        logic               crtc_reg;
        logic               crtc_dat;
        logic               serial;
        logic [N_ADAPT-1:0] adapt;
    } bus_class_t;

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] left;
        logic             dur_odd;
        logic             phase;
    } stretch_state_t;

    function automatic logic in_range(input logic [ADDR_W-1:0] a,
                                      input logic [ADDR_W-1:0] lo,
                                      input logic [ADDR_W-1:0] hi);
        return (a >= lo) && (a <= hi);
    endfunction

    function automatic logic [DUR_W-1:0] stretch_len(input logic phase);
        return DUR_W'(SLOW_BASE) + DUR_W'(phase);
    endfunction

endpackage

// File: rtl/sbs_addr_decode.sv
module sbs_addr_decode
    import sbs_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              active,
    output logic              is_slow,
    output bus_class_t        cls
);

    logic [N_SLOW-1:0]  slow_hit;
    logic [N_ADAPT-1:0] adapt_hit;
    logic               io_hit;
    logic               crtc_hit;

    genvar gi;
    generate
        for (gi = 0; gi < N_SLOW; gi++) begin : g_slow
            assign slow_hit[gi] = in_range(addr, SLOW_LO[gi], SLOW_HI[gi]);
        end
        for (gi = 0; gi < N_ADAPT; gi++) begin : g_adapt
            localparam logic [ADDR_W-1:0] LO = ADAPT_BASE + ADDR_W'(gi * ADAPT_SPAN);
            localparam logic [ADDR_W-1:0] HI = LO + ADDR_W'(ADAPT_SPAN - 1);
            assign adapt_hit[gi] = in_range(addr, LO, HI);
        end
    endgenerate

    assign io_hit   = in_range(addr, IO_LO, IO_HI);
    assign crtc_hit = in_range(addr, CRTC_LO, CRTC_HI);
    assign is_slow  = |slow_hit;

    always_comb begin
        cls          = '0;
        cls.io       = active && io_hit;
        cls.slow     = active && is_slow;
        cls.crtc_reg = active && crtc_hit && !addr[0];
        cls.crtc_dat = active && crtc_hit && addr[0];
        cls.serial   = active && in_range(addr, SERIAL_LO, SERIAL_HI);
        cls.adapt    = active ? adapt_hit : '0;
    end

    always_comb begin
        AST_SEL_EXCLUSIVE: assert ($onehot0({cls.crtc_reg, cls.crtc_dat, cls.serial, cls.adapt})); // R7
        AST_DEV_IS_SLOW: assert (!(cls.crtc_reg || cls.serial || |cls.adapt) || cls.slow); // R3
    end

endmodule

// File: rtl/sbs_stretch_ctrl.sv
module sbs_stretch_ctrl
    import sbs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic acc_valid,
    input  logic is_slow,
    output logic cpu_wait,
    output logic acc_done,
    output logic busy,
    output logic phase_odd
);

    stretch_state_t st_q, st_d;
    logic           start;
    logic [DUR_W-1:0] dur;

    assign start = acc_valid && !st_q.busy && !rst;
    assign dur   = is_slow ? stretch_len(st_q.phase) : DUR_W'(1);

    always_comb begin
        cpu_wait = 1'b0;
        acc_done = 1'b0;
        st_d     = st_q;
        if (rst) begin
            st_d = '0;
        end else if (st_q.busy) begin
            cpu_wait  = (st_q.left > CNT_W'(1));
            acc_done  = (st_q.left == CNT_W'(1));
            st_d.left = st_q.left - CNT_W'(1);
            if (st_q.left == CNT_W'(1)) begin
                st_d.busy  = 1'b0;
                st_d.phase = st_q.phase ^ st_q.dur_odd;
            end
        end else if (start) begin
            if (is_slow) begin
                cpu_wait     = 1'b1;
                st_d.busy    = 1'b1;
                st_d.left    = CNT_W'(dur - DUR_W'(1));
                st_d.dur_odd = dur[0];
            end else begin
                acc_done   = 1'b1;
                st_d.phase = ~st_q.phase;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign busy      = st_q.busy;
    assign phase_odd = st_q.phase;

    AST_STRETCH_MAX: assert property (@(posedge clk) disable iff (rst)
        (cpu_wait && $past(cpu_wait)) |=> !cpu_wait); // R4
    AST_WAIT_ENDS_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(cpu_wait) |-> acc_done); // R4
    AST_IDLE_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!acc_valid && !busy) |=> $stable(phase_odd)); // R5
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!phase_odd && !busy)); // R6

endmodule

// File: rtl/sbs_irq_merge.sv
module sbs_irq_merge #(
    parameter int N_SRC = 2
) (
    input  logic [N_SRC-1:0] src,
    output logic             irq
);

    logic [N_SRC:0] chain;

    assign chain[0] = 1'b0;
    genvar gi;
    generate
        for (gi = 0; gi < N_SRC; gi++) begin : g_or
            assign chain[gi+1] = chain[gi] | src[gi];
        end
    endgenerate

    assign irq = chain[N_SRC];

endmodule

// File: rtl/slow_bus_stretcher.sv
module slow_bus_stretcher
    import sbs_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                acc_valid,
    input  logic [15:0]         addr,
    input  logic [1:0]          adapt_irq,
    output logic                cpu_wait,
    output logic                acc_done,
    output logic                phase_odd,
    output logic                io_sel,
    output logic                slow_sel,
    output logic                crtc_reg_sel,
    output logic                crtc_dat_sel,
    output logic                serial_sel,
    output logic [1:0]          adapt_sel,
    output logic                cpu_irq
);

    logic       is_slow;
    logic       busy;
    logic       active;
    bus_class_t cls;

    assign active = (acc_valid || busy) && !rst;

    sbs_addr_decode u_decode (
        .addr    (addr),
        .active  (active),
        .is_slow (is_slow),
        .cls     (cls)
    );

    sbs_stretch_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .acc_valid (acc_valid),
        .is_slow   (is_slow),
        .cpu_wait  (cpu_wait),
        .acc_done  (acc_done),
        .busy      (busy),
        .phase_odd (phase_odd)
    );

    sbs_irq_merge #(.N_SRC(N_ADAPT)) u_irq (
        .src (adapt_irq),
        .irq (cpu_irq)
    );

    assign io_sel       = cls.io;
    assign slow_sel     = cls.slow;
    assign crtc_reg_sel = cls.crtc_reg;
    assign crtc_dat_sel = cls.crtc_dat;
    assign serial_sel   = cls.serial;
    assign adapt_sel    = cls.adapt;

    AST_WAIT_IS_SLOW: assert property (@(posedge clk) disable iff (rst)
        cpu_wait |-> slow_sel); // R2
    AST_SLOW_IS_IO: assert property (@(posedge clk) disable iff (rst)
        slow_sel |-> io_sel); // R3
    AST_SLOW_END_EVEN: assert property (@(posedge clk) disable iff (rst)
        (acc_done && slow_sel) |=> !phase_odd); // R5
    AST_FAST_FLIP: assert property (@(posedge clk) disable iff (rst)
        (acc_done && !slow_sel) |=> (phase_odd != $past(phase_odd))); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!acc_valid && !$past(cpu_wait)) |-> !(io_sel || acc_done || cpu_wait)); // R11

endmodule

// File: tb/slow_bus_stretcher_tb.sv
module slow_bus_stretcher_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        acc_valid;
    logic [15:0] addr;
    logic [1:0]  adapt_irq;
    logic        cpu_wait, acc_done, phase_odd, io_sel, slow_sel;
    logic        crtc_reg_sel, crtc_dat_sel, serial_sel, cpu_irq;
    logic [1:0]  adapt_sel;

    int checks = 0;
    int errors = 0;
    bit ph = 1'b0;

    always #2 clk = ~clk;

    slow_bus_stretcher u_dut (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .addr(addr),
        .adapt_irq(adapt_irq), .cpu_wait(cpu_wait), .acc_done(acc_done),
        .phase_odd(phase_odd), .io_sel(io_sel), .slow_sel(slow_sel),
        .crtc_reg_sel(crtc_reg_sel), .crtc_dat_sel(crtc_dat_sel),
        .serial_sel(serial_sel), .adapt_sel(adapt_sel), .cpu_irq(cpu_irq)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic logic [6:0] sel_vec();
        return {io_sel, slow_sel, crtc_reg_sel, crtc_dat_sel, serial_sel, adapt_sel};
    endfunction

    // Expected selects for an active access at address a
    function automatic logic [6:0] exp_sel(input int a);
        logic io, sl, cr, cd, se;
        logic [1:0] ad;
        io = (a >= 'hFC00) && (a < 'hFF00);
        sl = (a >= 'hFC00 && a < 'hFE00) || (a >= 'hFE00 && a < 'hFE18) ||
             (a >= 'hFE40 && a < 'hFE80) || (a >= 'hFEC0 && a < 'hFEE0);
        cr = (a >= 'hFE00) && (a < 'hFE08) && (a % 2 == 0);
        cd = (a >= 'hFE00) && (a < 'hFE08) && (a % 2 == 1);
        se = (a >= 'hFE08) && (a < 'hFE10);
        ad[0] = (a >= 'hFE40) && (a < 'hFE60);
        ad[1] = (a >= 'hFE60) && (a < 'hFE80);
        return {io, sl, cr, cd, se, ad};
    endfunction

    function automatic string region_tag(input int a);
        if (a < 'hFC00 || a >= 'hFF00) return "R1";
        if (a < 'hFE00) return "R2";
        if (a < 'hFE08) return "R7";
        if (a < 'hFE10) return "R8";
        if (a >= 'hFE40 && a < 'hFE80) return "R9";
        return "R3";
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; acc_valid = 1'b0; addr = 16'h0000; adapt_irq = 2'b00;
        repeat (3) @(negedge clk);
        #1;
        chk("R6", "wait in reset", int'(cpu_wait), 0);
        chk("R6", "phase in reset", int'(phase_odd), 0);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R6", "wait after reset", int'(cpu_wait), 0);
        chk("R6", "done after reset", int'(acc_done), 0);
        chk("R6", "phase after reset", int'(phase_odd), 0);
        chk("R11", "selects idle", int'(sel_vec()), 0);

        for (int i = 0; i < 4; i++) begin
            adapt_irq = 2'(i);
            #1;
            chk("R10", "irq merge", int'(cpu_irq), int'(i != 0));
        end
        adapt_irq = 2'b00;

        for (int a = 0; a < 65536; a++) begin
            logic [6:0] es;
            int dur;
            string tag;
            es  = exp_sel(a);
            dur = es[5] ? 2 + int'(ph) : 1;
            tag = es[5] ? "R4" : (es[6] ? "R3" : "R1");
            addr = 16'(a);
            acc_valid = 1'b1;
            #1;
            chk("R5", "phase at access start", int'(phase_odd), int'(ph));
            for (int k = 0; k < dur; k++) begin
                chk(tag, "wait", int'(cpu_wait), int'(k < dur - 1));
                chk(tag, "done", int'(acc_done), int'(k == dur - 1));
                chk(region_tag(a), "selects", int'(sel_vec()), int'(es));
                @(negedge clk);
                #1;
            end
            ph = ph ^ dur[0];
            if (a % 16 == 5) begin
                acc_valid = 1'b0;
                #1;
                chk("R11", "idle selects", int'(sel_vec()), 0);
                chk("R11", "idle wait/done", int'({cpu_wait, acc_done}), 0);
                @(negedge clk);
                #1;
                chk("R5", "phase held over idle", int'(phase_odd), int'(ph));
            end
        end

        acc_valid = 1'b0;
        @(negedge clk);
        #1;
        chk("R5", "final phase", int'(phase_odd), int'(ph));
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule